// File: doc/BRIEF.md
# VCO Band Calibration Controller

This block chooses one of four oscillators and a 6-bit capacitor-bank trim code so that a frequency synthesizer lands near a requested frequency. It never looks at an analog tuning voltage. It measures instead: a counter tallies the pulses coming out of the feedback divider during one period of a slow calibration clock. The calibration clock is the comparison clock divided by a programmable power of two. The measured count is then compared against a target count that software has computed from the wanted frequency.

A start pulse launches a run at once. There are three ways a run can go. In automatic mode the block first tries each oscillator at mid trim, then refines the trim with a successive-approximation search. In fixed-oscillator mode the oscillator comes from the manual select and only the trim is searched. In bypass mode the manual oscillator and trim settings pass straight through to the outputs. A separate test mode reuses the same counter as a frequency counter while the oscillator is pushed to the top or the bottom edge of its range. If the counter saturates, the run is flagged and its result is discarded.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, `osc_sel`, `trim_code`, `cal_done`, `cal_err`, `test_count`, `force_fmax` and `force_fmin` are all zero.
- R2: Measurement windows run back to back, each one calibration period long, with the first one beginning on the clock edge that samples `cal_start`. The period is 2^k comparison-clock cycles when `clk_scale` is `1kkk` (binary), and 1 cycle for any code with bit 3 clear. The scale is latched at start.
- R3: Automatic mode (`fixed_osc_mode`=0, `cal_bypass`=0) takes four windows at trim `100000`, one each for oscillators 0 to 3. It picks the lowest-numbered oscillator whose count is at least `target_cnt`, or oscillator 3 if none is. Six more windows then resolve the trim MSB first: a trial bit is kept when the count is not above `target_cnt`. `cal_done` rises 10 windows after start, which is within 46 calibration periods, and the trial settings appear on `osc_sel`/`trim_code` while they are being measured.
- R4: Fixed-oscillator mode (`fixed_osc_mode`=1) holds `osc_sel` at `man_osc` and runs only the six trim windows. `cal_done` rises 6 windows after start, which is within 34 calibration periods.
- R5: With `cal_bypass`=1 (and `test_en`=0), a start sets `cal_done` on the same edge, with `osc_sel`=`man_osc` and `trim_code`=`man_trim`.
- R6: A divider pulse that arrives while the measurement counter is all ones is an overflow. At the end of that window the run aborts with `cal_err`=1, `cal_done`=1, `osc_sel`=0 and `trim_code`=0.
- R7: A start with `test_en`=1 enters test mode. In test mode `force_fmax`=1 if `test_edge_min` was 0 at start, and `force_fmin`=1 otherwise; the two are never both set. At the end of every window, `test_count` takes that window's count, zero-extended. `cal_done` stays 0. Dropping `test_en` returns the block to idle with both force outputs low.
- R8: Once `cal_done` is set, `osc_sel` and `trim_code` hold until the next start. Changes on `man_osc`/`man_trim` have no effect on them.
- R9: A start clears `cal_err` and `test_count`, and it clears `cal_done` unless the start is a bypass start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Start pulse, one cycle |
| fixed_osc_mode | input | 1 | 1: oscillator taken from man_osc, trim searched |
| cal_bypass | input | 1 | 1: manual settings used directly |
| man_osc | input | OSC_W | Manual oscillator select |
| man_trim | input | TRIM_W | Manual trim code |
| clk_scale | input | 4 | Calibration clock scale code |
| target_cnt | input | CNT_W | Wanted count per calibration period |
| div_pulse | input | 1 | Feedback divider output, one pulse per cycle at most |
| test_en | input | 1 | Frequency-counter test mode |
| test_edge_min | input | 1 | Test edge: 0 maximum, 1 minimum frequency |
| osc_sel | output | OSC_W | Oscillator being measured or chosen |
| trim_code | output | TRIM_W | Trim being measured or chosen |
| cal_done | output | 1 | Run finished |
| cal_err | output | 1 | Counter overflow seen |
| test_count | output | TCNT_W | Count of the last test-mode window |
| force_fmax | output | 1 | Push oscillator to its top edge |
| force_fmin | output | 1 | Push oscillator to its bottom edge |

## Verification
Some internal faults show up directly at the ports. If the window length is off, the rise of `cal_done` moves by whole windows. A wrong keep decision in the trim search changes the final `trim_code` exactly at `cal_done`. A wrong oscillator pick puts a different `osc_sel` on the port as soon as the trim windows begin. If the saturation logic is wrong, a flooded window fails to raise `cal_err` one window after start. If test mode fails to clear its count, the stale value on `test_count` is visible within one cycle of the new start.

// File: rtl/vcocal_pkg.sv
// Shared types and constants for the oscillator band calibration block.
// Assumes calibration scale codes use bit 3 as "divide" and bits 2:0 as log2.
package vcocal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VSCAN = 2'd1,
        ST_TSCAN = 2'd2,
        ST_TEST  = 2'd3
    } cal_state_t;

    // Longest permitted runs, in calibration periods
    localparam int AUTO_BUDGET  = 46;
    localparam int FIXED_BUDGET = 34;

    // Map a scale code to log2 of the period; multiply codes clamp to x1
    function automatic logic [2:0] scale_shift(input logic [3:0] code);
        return code[3] ? code[2:0] : 3'd0;
    endfunction

endpackage

// File: rtl/vcocal_tick_gen.sv
// Calibration clock generator: emits a one-cycle tick at the end of every
// calibration period. Period is 2^shift comparison cycles, latched on restart.
// Assumes restart is a single-cycle pulse; restart realigns the phase.
module vcocal_tick_gen
    import vcocal_pkg::*;
#(
    parameter int MAX_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [3:0] scale_code,
    output logic       tick
);

    logic [MAX_LOG2-1:0] div_cnt;
    logic [MAX_LOG2-1:0] last_q;
    logic [2:0]          shift_raw;
    logic [MAX_LOG2:0]   one_hot;

    // Clamp the requested shift to what the divider can hold
    always_comb begin
        shift_raw = scale_shift(scale_code);
        if (int'(shift_raw) > MAX_LOG2)
            one_hot = (MAX_LOG2+1)'(1) << MAX_LOG2;
        else
            one_hot = (MAX_LOG2+1)'(1) << shift_raw;
    end

    assign tick = (div_cnt == last_q);

    // Latch the period on restart and count through it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            last_q  <= '0;
        end else if (restart) begin
            div_cnt <= '0;
            last_q  <= MAX_LOG2'(one_hot - (MAX_LOG2+1)'(1));
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + MAX_LOG2'(1);
        end
    end

endmodule

// File: rtl/vcocal_freq_meter.sv
// Gated pulse counter: tallies divider pulses within one calibration period.
// meas_val/meas_ovf are valid in the tick cycle and include that cycle's pulse.
// Assumes at most one pulse per comparison clock; saturates instead of wrapping.
module vcocal_freq_meter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             pulse,
    output logic [CNT_W-1:0] meas_val,
    output logic             meas_ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full;

    // Saturating next count and sticky overflow for the current window
    always_comb begin
        full     = &cnt_q;
        meas_val = (pulse && !full) ? cnt_q + CNT_W'(1) : cnt_q;
        meas_ovf = ovf_q | (pulse & full);
    end

    // Restart the window on clear or tick, else accumulate
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= meas_val;
            ovf_q <= meas_ovf;
        end
    end

endmodule

// File: rtl/vcocal_sar_step.sv
// One successive-approximation step on the trim code: resolves the bit under
// trial (keep or clear) and proposes the next trial with the next lower bit set.
// Assumes the trial code already has bit_idx set and lower bits clear.
module vcocal_sar_step #(
    parameter int TRIM_W = 6,
    parameter int BIT_W  = 3
) (
    input  logic [TRIM_W-1:0] trial,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              keep,
    output logic [TRIM_W-1:0] resolved,
    output logic [TRIM_W-1:0] next_trial
);

    for (genvar i = 0; i < TRIM_W; i++) begin : g_bit
        // Decide the bit under test, pass the others through
        assign resolved[i] = (BIT_W'(i) == bit_idx) ? (trial[i] & keep) : trial[i];
        // Set the next lower bit as the new trial
        assign next_trial[i] = resolved[i] |
                               ((bit_idx != '0) && (BIT_W'(i) == bit_idx - BIT_W'(1)));
    end

endmodule

// File: rtl/vco_band_cal.sv
// Oscillator band calibration controller. It picks an oscillator and a trim code
// by comparing gated divider counts with a target count. It also offers bypass
// and a frequency-counter test mode.
// Assumes div_pulse is synchronous to clk and a start pulse lasts one cycle.
module vco_band_cal
    import vcocal_pkg::*;
#(
    parameter int OSC_W    = 2,
    parameter int TRIM_W   = 6,
    parameter int CNT_W    = 18,
    parameter int TCNT_W   = 18,
    parameter int MAX_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              fixed_osc_mode,
    input  logic              cal_bypass,
    input  logic [OSC_W-1:0]  man_osc,
    input  logic [TRIM_W-1:0] man_trim,
    input  logic [3:0]        clk_scale,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic              div_pulse,
    input  logic              test_en,
    input  logic              test_edge_min,
    output logic [OSC_W-1:0]  osc_sel,
    output logic [TRIM_W-1:0] trim_code,
    output logic              cal_done,
    output logic              cal_err,
    output logic [TCNT_W-1:0] test_count,
    output logic              force_fmax,
    output logic              force_fmin
);

    localparam int BIT_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
    localparam logic [OSC_W-1:0]  LAST_OSC = '1;
    localparam logic [TRIM_W-1:0] MID_TRIM = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(TRIM_W - 1);

    cal_state_t        state_q;
    logic [OSC_W-1:0]  osc_q, pick_q;
    logic [TRIM_W-1:0] trim_q;
    logic [BIT_W-1:0]  bit_q;
    logic              found_q, done_q, err_q, fmax_q, fmin_q;
    logic [TCNT_W-1:0] tcount_q;

    logic              cal_tick;
    logic [CNT_W-1:0]  meas_val;
    logic              meas_ovf;
    logic              meas_hit, meas_keep;
    logic [TRIM_W-1:0] sar_resolved, sar_next;

    vcocal_tick_gen #(.MAX_LOG2(MAX_LOG2)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cal_start),
        .scale_code (clk_scale),
        .tick       (cal_tick)
    );

    vcocal_freq_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cal_start),
        .tick     (cal_tick),
        .pulse    (div_pulse),
        .meas_val (meas_val),
        .meas_ovf (meas_ovf)
    );

    vcocal_sar_step #(.TRIM_W(TRIM_W), .BIT_W(BIT_W)) u_sar (
        .trial      (trim_q),
        .bit_idx    (bit_q),
        .keep       (meas_keep),
        .resolved   (sar_resolved),
        .next_trial (sar_next)
    );

    // Compare the finished window against the target
    always_comb begin
        meas_hit  = (meas_val >= target_cnt);
        meas_keep = (meas_val <= target_cnt);
    end

    // Calibration sequencer: start decode, oscillator scan, trim search, test mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            osc_q    <= '0;
            pick_q   <= '0;
            trim_q   <= '0;
            bit_q    <= '0;
            found_q  <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            fmax_q   <= 1'b0;
            fmin_q   <= 1'b0;
            tcount_q <= '0;
        end else if (cal_start) begin
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            tcount_q <= '0;
            found_q  <= 1'b0;
            pick_q   <= '0;
            fmax_q   <= 1'b0;
            fmin_q   <= 1'b0;
            if (test_en) begin
                state_q <= ST_TEST;
                osc_q   <= man_osc;
                trim_q  <= man_trim;
                fmax_q  <= !test_edge_min;
                fmin_q  <= test_edge_min;
            end else if (cal_bypass) begin
                state_q <= ST_IDLE;
                osc_q   <= man_osc;
                trim_q  <= man_trim;
                done_q  <= 1'b1;
            end else if (fixed_osc_mode) begin
                state_q <= ST_TSCAN;
                osc_q   <= man_osc;
                trim_q  <= MID_TRIM;
                bit_q   <= TOP_BIT;
            end else begin
                state_q <= ST_VSCAN;
                osc_q   <= '0;
                trim_q  <= MID_TRIM;
            end
        end else begin
            case (state_q)
                ST_VSCAN: begin
                    if (cal_tick) begin
                        if (meas_ovf) begin
                            state_q <= ST_IDLE;
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            osc_q   <= '0;
                            trim_q  <= '0;
                        end else if (osc_q == LAST_OSC) begin
                            osc_q   <= found_q ? pick_q : LAST_OSC;
                            trim_q  <= MID_TRIM;
                            bit_q   <= TOP_BIT;
                            state_q <= ST_TSCAN;
                        end else begin
                            if (!found_q && meas_hit) begin
                                found_q <= 1'b1;
                                pick_q  <= osc_q;
                            end
                            osc_q <= osc_q + OSC_W'(1);
                        end
                    end
                end
                ST_TSCAN: begin
                    if (cal_tick) begin
                        if (meas_ovf) begin
                            state_q <= ST_IDLE;
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            osc_q   <= '0;
                            trim_q  <= '0;
                        end else if (bit_q == '0) begin
                            trim_q  <= sar_resolved;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            trim_q <= sar_next;
                            bit_q  <= bit_q - BIT_W'(1);
                        end
                    end
                end
                ST_TEST: begin
                    if (!test_en) begin
                        state_q <= ST_IDLE;
                        fmax_q  <= 1'b0;
                        fmin_q  <= 1'b0;
                    end else if (cal_tick) begin
                        tcount_q <= TCNT_W'(meas_val);
                        if (meas_ovf) err_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign osc_sel    = osc_q;
    assign trim_code  = trim_q;
    assign cal_done   = done_q;
    assign cal_err    = err_q;
    assign test_count = tcount_q;
    assign force_fmax = fmax_q;
    assign force_fmin = fmin_q;

endmodule

// File: rtl/vco_band_cal_checker.sv
// Property checker for the band calibration controller, bound to the top.
// Counts calibration ticks since the last start to bound run length.
module vco_band_cal_checker
    import vcocal_pkg::*;
#(
    parameter int OSC_W  = 2,
    parameter int TRIM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start,
    input logic              cal_bypass,
    input logic              fixed_osc_mode,
    input logic              test_en,
    input logic [OSC_W-1:0]  man_osc,
    input logic [TRIM_W-1:0] man_trim,
    input logic [OSC_W-1:0]  osc_sel,
    input logic [TRIM_W-1:0] trim_code,
    input logic              cal_done,
    input logic              cal_err,
    input logic              force_fmax,
    input logic              force_fmin,
    input logic              cal_tick
);

    logic [7:0] tick_cnt;
    logic [7:0] budget_q;

    // Tick count since the last start, and the budget of that run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            budget_q <= 8'(AUTO_BUDGET);
        end else if (cal_start) begin
            tick_cnt <= '0;
            budget_q <= fixed_osc_mode ? 8'(FIXED_BUDGET) : 8'(AUTO_BUDGET);
        end else if (cal_tick && tick_cnt != 8'hFF) begin
            tick_cnt <= tick_cnt + 8'd1;
        end
    end

    AST_RUN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> tick_cnt <= budget_q); // R3 R4

    AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start && cal_bypass && !test_en |=>
            cal_done && osc_sel == $past(man_osc) && trim_code == $past(man_trim)); // R5

    AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) && !$past(test_en) |-> cal_done); // R6

    AST_FORCE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({force_fmax, force_fmin})); // R7

    AST_TEST_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_fmax || force_fmin) |-> !cal_done); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done && !cal_start |=> cal_done && $stable(osc_sel) && $stable(trim_code)); // R8

    AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_err); // R9

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start && !(cal_bypass && !test_en) |=> !cal_done); // R9

endmodule

bind vco_band_cal vco_band_cal_checker #(.OSC_W(OSC_W), .TRIM_W(TRIM_W)) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cal_start      (cal_start),
    .cal_bypass     (cal_bypass),
    .fixed_osc_mode (fixed_osc_mode),
    .test_en        (test_en),
    .man_osc        (man_osc),
    .man_trim       (man_trim),
    .osc_sel        (osc_sel),
    .trim_code      (trim_code),
    .cal_done       (cal_done),
    .cal_err        (cal_err),
    .force_fmax     (force_fmax),
    .force_fmin     (force_fmin),
    .cal_tick       (cal_tick)
);

// File: tb/tb_vco_band_cal.sv
// Scoreboard bench: a driver pushes expected results, a monitor pops and compares.
// Oscillator model: count per 128-cycle window = 20*osc + trim (force max 100, min 10).
module tb_vco_band_cal;

    localparam int CNT_W  = 7;
    localparam int TCNT_W = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        fixed_osc_mode = 1'b0;
    logic        cal_bypass = 1'b0;
    logic [1:0]  man_osc = '0;
    logic [5:0]  man_trim = '0;
    logic [3:0]  clk_scale = 4'b1111;
    logic [CNT_W-1:0] target_cnt = '0;
    logic        div_pulse = 1'b0;
    logic        test_en = 1'b0;
    logic        test_edge_min = 1'b0;
    logic [1:0]  osc_sel;
    logic [5:0]  trim_code;
    logic        cal_done, cal_err, force_fmax, force_fmin;
    logic [TCNT_W-1:0] test_count;

    vco_band_cal #(.CNT_W(CNT_W), .TCNT_W(TCNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .fixed_osc_mode(fixed_osc_mode),
        .cal_bypass(cal_bypass), .man_osc(man_osc), .man_trim(man_trim),
        .clk_scale(clk_scale), .target_cnt(target_cnt), .div_pulse(div_pulse),
        .test_en(test_en), .test_edge_min(test_edge_min), .osc_sel(osc_sel),
        .trim_code(trim_code), .cal_done(cal_done), .cal_err(cal_err),
        .test_count(test_count), .force_fmax(force_fmax), .force_fmin(force_fmin)
    );

    always #5 clk = ~clk;

    typedef struct {
        string req;
        int    osc;
        int    trim;   // -1: not checked
        int    err;
        int    lat;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   start_cnt = 0;
    int   done_cnt  = 0;
    int   lat = 0;
    int   acc = 0;
    bit   flood = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Oscillator model driven away from the active edge
    always @(negedge clk) begin
        int c;
        int s;
        if (!rst_n) begin
            acc = 0;
            div_pulse = 1'b0;
        end else if (flood) begin
            div_pulse = 1'b1;
        end else begin
            c = force_fmax ? 100 : (force_fmin ? 10 : 20 * int'(osc_sel) + int'(trim_code));
            s = acc + 2 * c;
            div_pulse = (s >= 256);
            acc = s % 256;
        end
    end

    // Latency counter and start tally, sampled at the edge
    always @(posedge clk) begin
        if (cal_start) begin
            lat <= 0;
            if (!test_en) start_cnt <= start_cnt + 1;
        end else begin
            lat <= lat + 1;
        end
    end

    // Monitor: pop expected item once the pending run reports done
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && start_cnt != done_cnt && cal_done) begin
            e = sb_q.pop_front();
            chk(e.req, "osc_sel", int'(osc_sel), e.osc);
            if (e.trim >= 0) chk(e.req, "trim_code", int'(trim_code), e.trim);
            chk(e.req, "cal_err", int'(cal_err), e.err);
            chk(e.req, "latency", lat, e.lat);
            done_cnt = done_cnt + 1;
        end
    end

    function automatic int exp_osc(input int t);
        for (int v = 0; v < 4; v++) if (20 * v + 32 >= t) return v;
        return 3;
    endfunction

    function automatic int exp_trim(input int v, input int t);
        int r = t - 20 * v;
        if (r < 0) return 0;
        if (r > 63) return 63;
        return r;
    endfunction

    // Driver: push expectation, pulse start, wait for the monitor to consume it
    task automatic run_cal(input string req, input bit fixed, input bit byp, input int mosc,
                           input int mtrim, input int tgt, input logic [3:0] scale,
                           input int eo, input int et, input int ee, input int el);
        exp_t e;
        e.req = req; e.osc = eo; e.trim = et; e.err = ee; e.lat = el;
        sb_q.push_back(e);
        @(negedge clk);
        fixed_osc_mode = fixed;
        cal_bypass = byp;
        man_osc = 2'(mosc);
        man_trim = 6'(mtrim);
        target_cnt = CNT_W'(tgt);
        clk_scale = scale;
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        while (done_cnt != start_cnt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_auto(input string req, input int tgt);
        int v = exp_osc(tgt);
        run_cal(req, 1'b0, 1'b0, 0, 0, tgt, 4'b1111, v, exp_trim(v, tgt), 0, 10 * 128);
    endtask

    // Test mode: check the first window's count, then leave test mode
    task automatic run_test(input string req, input bit edge_min, input logic [3:0] scale,
                            input int period, input int expc);
        @(negedge clk);
        test_en = 1'b1;
        test_edge_min = edge_min;
        clk_scale = scale;
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk("R9", "test_count cleared by start", int'(test_count), 0);
        repeat (period + 2) @(negedge clk);
        chk(req, "test_count", int'(test_count), expc);
        chk(req, "force_fmax", int'(force_fmax), edge_min ? 0 : 1);
        chk(req, "force_fmin", int'(force_fmin), edge_min ? 1 : 0);
        chk(req, "cal_done in test", int'(cal_done), 0);
        test_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "force released", int'(force_fmax | force_fmin), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "osc_sel", int'(osc_sel), 0);
        chk("R1", "trim_code", int'(trim_code), 0);
        chk("R1", "cal_done", int'(cal_done), 0);
        chk("R1", "cal_err", int'(cal_err), 0);
        chk("R1", "test_count", int'(test_count), 0);
        chk("R1", "force", int'(force_fmax | force_fmin), 0);

        // R3 automatic search across targets
        run_auto("R3 t10", 10);
        run_auto("R3 t50", 50);
        run_auto("R3 t70", 70);
        run_auto("R3 t120", 120);
        run_auto("R3 t127", 127);
        run_auto("R3 t0", 0);

        // R4 fixed-oscillator search
        run_cal("R4 osc2", 1'b1, 1'b0, 2, 0, 50, 4'b1111, 2, 10, 0, 6 * 128);
        run_cal("R4 osc3", 1'b1, 1'b0, 3, 0, 30, 4'b1111, 3, 0, 0, 6 * 128);

        // R2 multiply codes clamp to one-cycle windows
        run_cal("R2 x1", 1'b1, 1'b0, 1, 0, 40, 4'b0100, 1, -1, 0, 6);

        // R5 bypass
        run_cal("R5 bypass", 1'b0, 1'b1, 1, 45, 0, 4'b1111, 1, 45, 0, 0);

        // R8 manual inputs ignored after done
        man_osc = 2'd3;
        man_trim = 6'd7;
        repeat (5) @(negedge clk);
        chk("R8", "osc_sel held", int'(osc_sel), 1);
        chk("R8", "trim_code held", int'(trim_code), 45);

        // R6 overflow aborts after first window
        flood = 1'b1;
        run_cal("R6 overflow", 1'b0, 1'b0, 0, 0, 50, 4'b1111, 0, 0, 1, 128);
        flood = 1'b0;
        chk("R6", "cal_done after overflow", int'(cal_done), 1);

        // R9 new start clears error
        run_auto("R9 clear err", 50);

        // R7 and R2 test mode counts at several scales
        run_test("R7 max 1/128", 1'b0, 4'b1111, 128, 100);
        run_test("R2 min 1/64", 1'b1, 4'b1110, 64, 5);
        run_test("R2 max 1/32", 1'b0, 4'b1101, 32, 25);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule